// File: doc/BRIEF.md
# Range Decoder Bank with Committed Snapshots

This block holds a small bank of host-address range decoders. Software programs each decoder's base and size through a one-cycle register write port, then raises a commit bit. A multi-cycle sequencer then checks the programmed window against every other decoder that is currently active. If the check passes, the sequencer copies base and size into hidden shadow registers. Address lookup is combinational. It reports whether an address falls inside an active decoder's shadow window, and which decoder that is. The live base and size registers never steer decoding.

Commit requests are serialized. A rising commit bit marks its decoder as pending, and one shared sequencer serves pending decoders in ascending index order. A range clash sets an error flag instead of activating the decoder. Software can therefore move adjacent windows safely by uncommitting them and recommitting them in a chosen order. A lock bit freezes an active decoder's control word, and it also shields base and size from writes while that decoder's check is running. A parameter chooses what clearing the commit bit does to an active decoder.

Top module: `range_commit_decoder`

## Requirements
- R1: A write that moves a decoder's commit bit from 0 to 1 reads back committed=0 from the next cycle on. If the check passes, committed reads 1 once COMMIT_CYC+1 rising edges have followed the write edge, and not before.
- R2: While a decoder stays committed, writes to its base or size registers do not change lookup results; only the window captured at the last successful commit decodes.
- R3: With CLEAR_ON_UNCOMMIT=1, a write moving commit from 1 to 0 clears committed and removes the decoder from lookup.
- R4: With CLEAR_ON_UNCOMMIT=0, a write moving commit from 1 to 0 leaves committed and the decoded window unchanged.
- R5: Lookup considers only decoders with committed=1. It reports hit=1 and the lowest matching decoder index, or hit=0 and index 0 when nothing matches.
- R6: When a decoder has both lock and committed set, control-word writes to it are ignored (commit, lock and committed keep their values).
- R7: When a decoder's lock bit is set and its commit is pending or being checked, writes to its base and size registers are ignored.
- R8: A commit whose window overlaps the shadow window of another committed decoder fails: the error bit reads 1 and committed stays 0.
- R9: The error bit survives a 1-to-0 commit write and clears only on the next 0-to-1 commit write.
- R10: A window spans base up to but excluding base+size. A size of zero matches no address and overlaps nothing, and windows that only touch end-to-start do not overlap.
- R11: Register select 0 is base, 1 is size and 2 is the control word. Control bit 0 is commit and bit 1 is lock, both writable; bit 2 is committed and bit 3 is error, both read-only. All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| wrDec | input | 2 | Decoder addressed by the write |
| wrSel | input | 2 | Register select for the write (0 base, 1 size, 2 control) |
| wrData | input | ADDR_W | Write data |
| rdDec | input | 2 | Decoder addressed by the read |
| rdSel | input | 2 | Register select for the read |
| rdData | output | ADDR_W | Combinational read data |
| lookupAddr | input | ADDR_W | Address to decode |
| hit | output | 1 | Address lies inside an active decoder's window |
| hitIdx | output | 2 | Index of the matching decoder |

## Verification
The assertions assume that COMMIT_CYC is at least NUM_DEC, so every decoder is visited during a sequence. They also assume that software does not change a decoder's base or size between its commit request and the end of its check unless the lock bit protects them; otherwise the stored window may differ from the window that was checked. The random stimulus keeps to this by issuing every operation alone and waiting out the full commit latency after each control write. The single directed case that writes base during a check sets the lock bit first, so that write must be dropped.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;
  localparam int IDX_W = 2;

  localparam int CTL_COMMIT = 0;
  localparam int CTL_LOCK   = 1;
  localparam int CTL_DONE   = 2;
  localparam int CTL_ERR    = 3;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             busy;
    logic             start;
    logic             finishOk;
    logic             finishFail;
    logic [IDX_W-1:0] idx;
    logic             chkValid;
    logic [IDX_W-1:0] chkIdx;
  } seqStrobe_t;
endpackage

// File: rtl/rdc_commit_seq.sv
`timescale 1ns/1ps
module rdc_commit_seq
  import rdc_pkg::*;
#(
  parameter int NUM_DEC    = 4,
  parameter int COMMIT_CYC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEC-1:0] pendVec,
  input  logic [NUM_DEC-1:0] abortVec,
  input  logic               overlapHit,
  output seqStrobe_t         strobe
);
  localparam int CNT_W = $clog2(COMMIT_CYC) + 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] cur;
  logic             failSeen;

  logic             pickAny;
  logic [IDX_W-1:0] pickIdx;
  logic             lastCyc;
  logic             aborted;
  logic             chkValid;
  logic             failNow;

  always_comb begin
    pickAny = 1'b0;
    pickIdx = '0;
    for (int k = NUM_DEC - 1; k >= 0; k--) begin
      if (pendVec[k] && !abortVec[k]) begin
        pickAny = 1'b1;
        pickIdx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    lastCyc  = busy && (cnt == CNT_W'(COMMIT_CYC - 1));
    aborted  = busy && abortVec[cur];
    chkValid = busy && (cnt < CNT_W'(NUM_DEC)) && (cnt[IDX_W-1:0] != cur);
    failNow  = chkValid && overlapHit;

    strobe.busy       = busy;
    strobe.start      = !busy && pickAny;
    strobe.idx        = busy ? cur : pickIdx;
    strobe.chkValid   = chkValid;
    strobe.chkIdx     = cnt[IDX_W-1:0];
    strobe.finishOk   = lastCyc && !aborted && !failSeen && !failNow;
    strobe.finishFail = lastCyc && !aborted && (failSeen || failNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      cur      <= '0;
      failSeen <= 1'b0;
    end else if (!busy) begin
      if (pickAny) begin
        busy     <= 1'b1;
        cur      <= pickIdx;
        cnt      <= '0;
        failSeen <= 1'b0;
      end
    end else if (aborted || lastCyc) begin
      busy <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
      failSeen <= failSeen || failNow;
    end
  end

  // R1: the decoder taken by the sequencer is no longer pending afterwards
  assert_start_clears_pend_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> !pendVec[$past(strobe.idx)]);
endmodule

// File: rtl/rdc_range_bank.sv
`timescale 1ns/1ps
module rdc_range_bank
  import rdc_pkg::*;
#(
  parameter int NUM_DEC           = 4,
  parameter int ADDR_W            = 16,
  parameter int CLEAR_ON_UNCOMMIT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrDec,
  input  logic [1:0]         wrSel,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic [IDX_W-1:0]   rdDec,
  input  logic [1:0]         rdSel,
  output logic [ADDR_W-1:0]  rdData,
  input  logic [ADDR_W-1:0]  lookupAddr,
  output logic               hit,
  output logic [IDX_W-1:0]   hitIdx,
  input  seqStrobe_t         strobe,
  output logic [NUM_DEC-1:0] pendVec,
  output logic [NUM_DEC-1:0] abortVec,
  output logic               overlapHit
);
  localparam int END_W = ADDR_W + 1;

  logic [ADDR_W-1:0]  baseReg [NUM_DEC];
  logic [ADDR_W-1:0]  sizeReg [NUM_DEC];
  logic [ADDR_W-1:0]  shBase  [NUM_DEC];
  logic [ADDR_W-1:0]  shSize  [NUM_DEC];
  logic [NUM_DEC-1:0] commitBit, lockBit, doneBit, errBit, pendBit;

  logic [NUM_DEC-1:0] ctrlWr, rise, fall, inCheck, baseWr, sizeWr, ownSeq;

  always_comb begin
    for (int k = 0; k < NUM_DEC; k++) begin
      ctrlWr[k]  = wrEn && (wrDec == IDX_W'(k)) && (wrSel == SEL_CTRL)
                   && !(lockBit[k] && doneBit[k]);
      rise[k]    = ctrlWr[k] && wrData[CTL_COMMIT] && !commitBit[k];
      fall[k]    = ctrlWr[k] && !wrData[CTL_COMMIT] && commitBit[k];
      ownSeq[k]  = (strobe.idx == IDX_W'(k));
      inCheck[k] = pendBit[k] || (strobe.busy && ownSeq[k]);
      baseWr[k]  = wrEn && (wrDec == IDX_W'(k)) && (wrSel == SEL_BASE)
                   && !(lockBit[k] && inCheck[k]);
      sizeWr[k]  = wrEn && (wrDec == IDX_W'(k)) && (wrSel == SEL_SIZE)
                   && !(lockBit[k] && inCheck[k]);
    end
  end

  assign pendVec  = pendBit;
  assign abortVec = fall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitBit <= '0;
      lockBit   <= '0;
      doneBit   <= '0;
      errBit    <= '0;
      pendBit   <= '0;
      for (int k = 0; k < NUM_DEC; k++) begin
        baseReg[k] <= '0;
        sizeReg[k] <= '0;
        shBase[k]  <= '0;
        shSize[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < NUM_DEC; k++) begin
        if (baseWr[k]) baseReg[k] <= wrData;
        if (sizeWr[k]) sizeReg[k] <= wrData;
        if (ctrlWr[k]) begin
          commitBit[k] <= wrData[CTL_COMMIT];
          lockBit[k]   <= wrData[CTL_LOCK];
        end
        if (rise[k])                                    pendBit[k] <= 1'b1;
        else if (fall[k] || (strobe.start && ownSeq[k])) pendBit[k] <= 1'b0;

        if (rise[k])                                     doneBit[k] <= 1'b0;
        else if (fall[k] && (CLEAR_ON_UNCOMMIT != 0))    doneBit[k] <= 1'b0;
        else if (strobe.finishOk && ownSeq[k])           doneBit[k] <= 1'b1;

        if (rise[k])                                errBit[k] <= 1'b0;
        else if (strobe.finishFail && ownSeq[k])    errBit[k] <= 1'b1;

        if (strobe.finishOk && ownSeq[k]) begin
          shBase[k] <= baseReg[k];
          shSize[k] <= sizeReg[k];
        end
      end
    end
  end

  // candidate (live registers) against one active shadow window per cycle
  logic [END_W-1:0] candEnd, otherEnd;
  always_comb begin
    candEnd    = {1'b0, baseReg[strobe.idx]} + {1'b0, sizeReg[strobe.idx]};
    otherEnd   = {1'b0, shBase[strobe.chkIdx]} + {1'b0, shSize[strobe.chkIdx]};
    overlapHit = strobe.chkValid && doneBit[strobe.chkIdx]
                 && (sizeReg[strobe.idx] != '0) && (shSize[strobe.chkIdx] != '0)
                 && ({1'b0, baseReg[strobe.idx]} < otherEnd)
                 && ({1'b0, shBase[strobe.chkIdx]} < candEnd);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int k = NUM_DEC - 1; k >= 0; k--) begin
      if (doneBit[k] && (shSize[k] != '0)
          && (lookupAddr >= shBase[k])
          && ({1'b0, lookupAddr} < ({1'b0, shBase[k]} + {1'b0, shSize[k]}))) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_DEC; k++) begin
      if (rdDec == IDX_W'(k)) begin
        case (rdSel)
          SEL_BASE: rdData = baseReg[k];
          SEL_SIZE: rdData = sizeReg[k];
          SEL_CTRL: rdData = ADDR_W'({errBit[k], doneBit[k], lockBit[k], commitBit[k]});
          default:  rdData = '0;
        endcase
      end
    end
  end

  // R5: a reported hit always names an active decoder
  assert_hit_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> doneBit[hitIdx]);

  for (genvar g = 0; g < NUM_DEC; g++) begin : gChk
    // R1: activation only comes from a successful sequence for this decoder
    assert_done_from_seq_R1: assert property (@(posedge clk) disable iff (!rstN)
      $rose(doneBit[g]) |-> $past(strobe.finishOk && (strobe.idx == IDX_W'(g))));
    // R2: shadow window frozen while the decoder stays active
    assert_shadow_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
      (doneBit[g] && $past(doneBit[g])) |-> ($stable(shBase[g]) && $stable(shSize[g])));
    // R6: locked active decoder keeps its control state
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      (lockBit[g] && doneBit[g]) |=>
        (lockBit[g] && doneBit[g] && (commitBit[g] == $past(commitBit[g]))));
    // R7: locked range registers frozen during the check
    assert_lock_range_R7: assert property (@(posedge clk) disable iff (!rstN)
      (lockBit[g] && inCheck[g]) |=> ($stable(baseReg[g]) && $stable(sizeReg[g])));
    // R8: a failed decoder is never active
    assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
      !(doneBit[g] && errBit[g]));
  end
endmodule

// File: rtl/range_commit_decoder.sv
`timescale 1ns/1ps
module range_commit_decoder
  import rdc_pkg::*;
#(
  parameter int NUM_DEC           = 4,
  parameter int ADDR_W            = 16,
  parameter int COMMIT_CYC        = 4,
  parameter int CLEAR_ON_UNCOMMIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrDec,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [1:0]        rdDec,
  input  logic [1:0]        rdSel,
  output logic [ADDR_W-1:0] rdData,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hit,
  output logic [1:0]        hitIdx
);
  seqStrobe_t         strobe;
  logic [NUM_DEC-1:0] pendVec;
  logic [NUM_DEC-1:0] abortVec;
  logic               overlapHit;

  rdc_commit_seq #(
    .NUM_DEC   (NUM_DEC),
    .COMMIT_CYC(COMMIT_CYC)
  ) seq_i (
    .clk       (clk),
    .rstN      (rstN),
    .pendVec   (pendVec),
    .abortVec  (abortVec),
    .overlapHit(overlapHit),
    .strobe    (strobe)
  );

  rdc_range_bank #(
    .NUM_DEC          (NUM_DEC),
    .ADDR_W           (ADDR_W),
    .CLEAR_ON_UNCOMMIT(CLEAR_ON_UNCOMMIT)
  ) bank_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrDec     (wrDec),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .rdDec     (rdDec),
    .rdSel     (rdSel),
    .rdData    (rdData),
    .lookupAddr(lookupAddr),
    .hit       (hit),
    .hitIdx    (hitIdx),
    .strobe    (strobe),
    .pendVec   (pendVec),
    .abortVec  (abortVec),
    .overlapHit(overlapHit)
  );
endmodule

// File: tb/range_commit_decoder_tb_top.sv
`timescale 1ns/1ps
module range_commit_decoder_tb_top;
  localparam int ND  = 4;
  localparam int AW  = 16;
  localparam int CYC = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrDec = '0, wrSel = '0, rdDec = '0, rdSel = '0;
  logic [AW-1:0] wrData = '0, lookupAddr = '0;
  logic [AW-1:0] rdA, rdB;
  logic          hitA, hitB;
  logic [1:0]    idxA, idxB;

  range_commit_decoder #(.NUM_DEC(ND), .ADDR_W(AW), .COMMIT_CYC(CYC), .CLEAR_ON_UNCOMMIT(1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDec(wrDec), .wrSel(wrSel), .wrData(wrData),
    .rdDec(rdDec), .rdSel(rdSel), .rdData(rdA), .lookupAddr(lookupAddr), .hit(hitA), .hitIdx(idxA));

  range_commit_decoder #(.NUM_DEC(ND), .ADDR_W(AW), .COMMIT_CYC(CYC), .CLEAR_ON_UNCOMMIT(0)) dutB_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDec(wrDec), .wrSel(wrSel), .wrData(wrData),
    .rdDec(rdDec), .rdSel(rdSel), .rdData(rdB), .lookupAddr(lookupAddr), .hit(hitB), .hitIdx(idxB));

  // reference state per policy: index 0 clears on uncommit, index 1 keeps
  logic [AW-1:0] mB [2][ND], mS [2][ND], shB [2][ND], shS [2][ND];
  bit            mC [2][ND], mL [2][ND], mCd [2][ND], mE [2][ND];

  int  nChk = 0, nFail = 0;
  bit  finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ovl(input logic [AW-1:0] b0, s0, b1, s1);
    logic [AW:0] e0, e1;
    e0 = {1'b0, b0} + {1'b0, s0};
    e1 = {1'b0, b1} + {1'b0, s1};
    return (s0 != 0) && (s1 != 0) && ({1'b0, b0} < e1) && ({1'b0, b1} < e0);
  endfunction

  function automatic logic [AW-1:0] expReg(input int p, input int d, input int sel);
    case (sel)
      0: return mB[p][d];
      1: return mS[p][d];
      2: return AW'({mE[p][d], mCd[p][d], mL[p][d], mC[p][d]});
      default: return '0;
    endcase
  endfunction

  function automatic logic [2:0] expLook(input int p, input logic [AW-1:0] a);
    for (int k = 0; k < ND; k++)
      if (mCd[p][k] && shS[p][k] != 0 && a >= shB[p][k] &&
          ({1'b0, a} < {1'b0, shB[p][k]} + {1'b0, shS[p][k]}))
        return {1'b1, 2'(k)};
    return 3'b000;
  endfunction

  task automatic modelReset();
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < ND; k++) begin
        mB[p][k] = 0; mS[p][k] = 0; shB[p][k] = 0; shS[p][k] = 0;
        mC[p][k] = 0; mL[p][k] = 0; mCd[p][k] = 0; mE[p][k] = 0;
      end
  endtask

  task automatic modelWrite(input int d, input int sel, input logic [AW-1:0] v);
    for (int p = 0; p < 2; p++) begin
      if (sel == 0) mB[p][d] = v;
      else if (sel == 1) mS[p][d] = v;
      else if (sel == 2 && !(mL[p][d] && mCd[p][d])) begin
        bit rs, fl, bad;
        rs = v[0] && !mC[p][d];
        fl = !v[0] && mC[p][d];
        mC[p][d] = v[0];
        mL[p][d] = v[1];
        if (rs) begin
          bad = 0;
          for (int j = 0; j < ND; j++)
            if (j != d && mCd[p][j] && ovl(mB[p][d], mS[p][d], shB[p][j], shS[p][j])) bad = 1;
          mE[p][d]  = bad;
          mCd[p][d] = !bad;
          if (!bad) begin shB[p][d] = mB[p][d]; shS[p][d] = mS[p][d]; end
        end else if (fl && p == 0) mCd[p][d] = 0;
      end
    end
  endtask

  // called at (or just after) a falling edge; returns at the next falling edge
  task automatic busWrite(input int d, input int sel, input logic [AW-1:0] v);
    wrEn = 1'b1; wrDec = 2'(d); wrSel = 2'(sel); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wr(input int d, input int sel, input logic [AW-1:0] v);
    modelWrite(d, sel, v);
    busWrite(d, sel, v);
    if (sel == 2) repeat (CYC + 1) @(negedge clk);
  endtask

  task automatic chkReg(input int d, input int sel, input string tag);
    rdDec = 2'(d); rdSel = 2'(sel); #1;
    check({tag, " policyA"}, 32'(rdA), 32'(expReg(0, d, sel)));
    check({tag, " policyB"}, 32'(rdB), 32'(expReg(1, d, sel)));
  endtask

  task automatic chkCtrlHand(input int d, input logic [AW-1:0] v, input string tag);
    rdDec = 2'(d); rdSel = 2'd2; #1;
    check({tag, " policyA"}, 32'(rdA), 32'(v));
    check({tag, " policyB"}, 32'(rdB), 32'(v));
  endtask

  task automatic chkLook(input logic [AW-1:0] a, input string tag);
    lookupAddr = a; #1;
    check({tag, " policyA"}, 32'({hitA, idxA}), 32'(expLook(0, a)));
    check({tag, " policyB"}, 32'({hitB, idxB}), 32'(expLook(1, a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    chkReg(0, 2, "R11 reset control word");
    chkReg(1, 0, "R11 reset base");
    chkLook(16'h1000, "R5 reset lookup");

    // first commit and its latency
    wr(0, 0, 16'h1000);
    wr(0, 1, 16'h0100);
    modelWrite(0, 2, 16'h1);
    busWrite(0, 2, 16'h1);
    chkCtrlHand(0, 16'h1, "R1 committed low after commit write");
    repeat (CYC) @(negedge clk);
    chkCtrlHand(0, 16'h1, "R1 committed not early");
    @(negedge clk);
    chkReg(0, 2, "R1 committed after sequence");
    chkLook(16'h1000, "R10 window start");
    chkLook(16'h10FF, "R10 window last");
    chkLook(16'h1100, "R10 window end excluded");
    chkLook(16'h0FFF, "R5 below window");

    // touching neighbour commits
    wr(1, 0, 16'h1100); wr(1, 1, 16'h0100); wr(1, 2, 16'h1);
    chkReg(1, 2, "R10 touching windows commit");
    chkLook(16'h1100, "R10 neighbour lookup");

    // overlapping request fails
    wr(2, 0, 16'h10F0); wr(2, 1, 16'h0020); wr(2, 2, 16'h1);
    chkReg(2, 2, "R8 overlap error");
    chkLook(16'h10F8, "R8 failed decoder not in lookup");

    // error persistence and clearing
    wr(2, 0, 16'h3000);
    wr(2, 2, 16'h0);
    chkReg(2, 2, "R9 error kept on uncommit");
    wr(2, 2, 16'h1);
    chkReg(2, 2, "R9 error cleared by new commit");
    chkLook(16'h3010, "R9 recommitted lookup");

    // snapshot decoding
    wr(0, 0, 16'h5000);
    chkLook(16'h1000, "R2 old window still decodes");
    chkLook(16'h5000, "R2 new base not yet decoding");
    chkReg(0, 0, "R11 base readback");

    // clear policy
    wr(0, 2, 16'h0);
    chkReg(0, 2, "R3 and R4 uncommit effect");
    chkLook(16'h1000, "R3 and R4 uncommitted lookup");
    modelWrite(0, 2, 16'h1);
    busWrite(0, 2, 16'h1);
    chkCtrlHand(0, 16'h1, "R1 recommit drops committed");
    repeat (CYC + 1) @(negedge clk);
    chkLook(16'h5000, "R1 recommit new window");
    chkLook(16'h1000, "R1 recommit old window gone");

    // lock on an active decoder
    wr(3, 0, 16'h7000); wr(3, 1, 16'h0010); wr(3, 2, 16'h3);
    wr(3, 2, 16'h0);
    chkReg(3, 2, "R6 locked control write ignored");
    chkLook(16'h7008, "R6 locked decoder still active");

    // lock during check protects base
    wr(1, 2, 16'h0);
    modelWrite(1, 2, 16'h3);
    busWrite(1, 2, 16'h3);
    busWrite(1, 0, 16'h9000);
    repeat (CYC) @(negedge clk);
    chkReg(1, 0, "R7 base write during check ignored");
    chkLook(16'h1100, "R7 committed window");
    chkLook(16'h9000, "R7 dropped base not decoding");

    // zero size
    wr(2, 2, 16'h0); wr(2, 1, 16'h0); wr(2, 0, 16'h5000); wr(2, 2, 16'h1);
    chkReg(2, 2, "R10 zero size commits without overlap");
    chkLook(16'h5000, "R10 zero size never matches");

    // random phase
    for (int n = 0; n < 160; n++) begin
      int d, r;
      logic [AW-1:0] v;
      d = $urandom % ND;
      r = $urandom % 8;
      if (r < 3)      wr(d, 0, AW'(($urandom % 32) * 16'h80));
      else if (r < 5) wr(d, 1, AW'(($urandom % 4) * 16'h80));
      else begin
        v = '0;
        v[0] = 1'($urandom % 2);
        v[1] = ($urandom % 10) == 0;
        wr(d, 2, v);
      end
      chkReg($urandom % ND, $urandom % 3, "R11 random readback");
      chkLook(AW'($urandom % 16'h1000), "R5 R8 R10 random lookup");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule